// File: doc/BRIEF.md
# Prescaler-Tap Watchdog Timer

This block guards against a runaway program. It counts carries from one tap of a free-running prescaler with a 2-bit counter. If software does not clear the counter before it wraps, the block raises a one-cycle CPU reset request. The prescaler is outside the block and feeds in two tap vectors: one for the main oscillator and one for the sub clock. A clock-mode select and a 2-bit interval select choose which bit of those vectors serves as the carry source. Carries are always taken from the live tap, so clearing the prescaler while the watchdog runs makes the effective interval longer.

Software controls the block through a single control bit. The first write of 0 while the block is stopped starts it and latches the clock mode and interval. Every later write of 0 clears the counter. External and software resets also clear the counter. Entry into any of three low-power modes clears the counter and suspends counting until the mode is left.

The controller has three states: STOP, RUN and SUSPEND. Its transitions are:
- START: STOP→RUN, or STOP→SUSPEND when a low-power mode is already active.
- SLEEP_IN: RUN→SUSPEND.
- WAKE: SUSPEND→RUN.
- BITE: RUN→STOP, on the overflow carry.

Power-on reset forces STOP asynchronously.

Top module: `tapdog_wdt`

## Requirements
- R1: While `por_n` is low, and after it is released, `running` and `rst_req` are 0. While stopped, a write with `wr_ctl_bit`=1 does not start the block.
- R2: A write (`wr_en`=1) with `wr_ctl_bit`=0 while stopped starts the block. `running` is 1 from the next cycle, and `osc_sel` and `ival_sel` are latched in that cycle.
- R3: A carry is a rising edge of the selected tap, seen against the previous cycle's value. With `osc_sel`=0, `ival_sel` 0..3 selects `main_pre` bit 11, 13, 15 or 18. With `osc_sel`=1, it selects `sub_pre` bit 9, 12, 13 or 14. A tap that is already high when the block starts is not a carry.
- R4: The fourth carry after a start or clear, with no clear in between, raises `rst_req` for exactly one cycle, in the cycle after that carry. `running` is 0 in that same cycle.
- R5: While running, a write of 0 to the control bit clears the counter. A write of 1 has no effect.
- R6: Changes to `osc_sel` and `ival_sel` while running, including those that come with a clearing write, have no effect on the interval.
- R7: A high `ext_rst` or `sw_rst` clears the counter. The block keeps running.
- R8: While any of `lp_sleep`, `lp_tbase` or `lp_stop` is high, the counter is held clear and carries are ignored. Counting resumes once all three are low.
- R9: A clear (control write, `ext_rst` or `sw_rst`) in the same cycle as the overflow carry wins, and no reset request is raised.
- R10: After a reset request, the block stays stopped until the next start write.
- R11: Clearing the prescaler while the block runs delays the timeout past its nominal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| osc_sel | input | 1 | Clock mode for start: 0 main oscillator, 1 sub clock |
| ival_sel | input | 2 | Interval select for start |
| wr_en | input | 1 | Control register write strobe |
| wr_ctl_bit | input | 1 | Written control bit; 0 starts or clears |
| main_pre | input | 19 | Main-oscillator prescaler bits |
| sub_pre | input | 15 | Sub-clock prescaler bits |
| ext_rst | input | 1 | External reset, clears counter |
| sw_rst | input | 1 | Software reset, clears counter |
| lp_sleep | input | 1 | Sleep mode active |
| lp_tbase | input | 1 | Timebase-only mode active |
| lp_stop | input | 1 | Stop mode active |
| rst_req | output | 1 | One-cycle CPU reset request |
| running | output | 1 | Watchdog started and not yet bitten |

## Verification
The key collision is a clear arriving in the same cycle as the carry that would overflow the counter. The bench waits until its own model holds a count of three and a rising tap edge is pending for the next clock edge. It then drives a clearing control write, and later an external reset, into exactly that cycle. The outcome is judged both ways: the reference model must show no reset request, and the design must then need four further carries before it bites.

// File: rtl/tapdog_pkg.sv
package tapdog_pkg;

    localparam int CNT_W    = 2;
    localparam int N_IVAL   = 4;
    localparam int MAIN_W   = 19;
    localparam int SUB_W    = 15;

    typedef enum logic [1:0] {
        ST_STOP    = 2'd0,
        ST_RUN     = 2'd1,
        ST_SUSPEND = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic       mode;
        logic [1:0] sel;
    } wd_cfg_t;

    // log2 of nominal timeout in source clock cycles, per interval select
    function automatic int timeout_log2(input bit sub_mode, input int sel);
        int r;
        if (!sub_mode) begin
            unique case (sel)
                0: r = 14;
                1: r = 16;
                2: r = 18;
                default: r = 21;
            endcase
        end else begin
            unique case (sel)
                0: r = 12;
                1: r = 15;
                2: r = 16;
                default: r = 17;
            endcase
        end
        return r;
    endfunction

    // Carry period is timeout / 2^CNT_W; a bit k rises every 2^(k+1) counts
    function automatic int tap_pos(input bit sub_mode, input int sel);
        return timeout_log2(sub_mode, sel) - CNT_W - 1;
    endfunction

endpackage

// File: rtl/tapdog_tap_pick.sv
module tapdog_tap_pick
    import tapdog_pkg::*;
#(
    parameter int  W        = 19,
    parameter bit  SUB_MODE = 1'b0
) (
    input  logic [W-1:0]      pre,
    output logic [N_IVAL-1:0] taps
);

    for (genvar i = 0; i < N_IVAL; i++) begin : g_tap
        localparam int POS = tap_pos(SUB_MODE, i);
        assign taps[i] = pre[POS];
    end

endmodule

// File: rtl/tapdog_carry.sv
module tapdog_carry
    import tapdog_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic [N_IVAL-1:0] main_taps,
    input  logic [N_IVAL-1:0] sub_taps,
    input  wd_cfg_t           cfg,
    output logic              carry
);

    logic [N_IVAL-1:0] main_prev_q;
    logic [N_IVAL-1:0] sub_prev_q;
    logic [N_IVAL-1:0] main_rise;
    logic [N_IVAL-1:0] sub_rise;

    // Every tap keeps its own history so a change of selection never
    // compares against a different bit.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            main_prev_q <= '0;
            sub_prev_q  <= '0;
        end else begin
            main_prev_q <= main_taps;
            sub_prev_q  <= sub_taps;
        end
    end

    assign main_rise = main_taps & ~main_prev_q;
    assign sub_rise  = sub_taps  & ~sub_prev_q;

    always_comb begin
        if (cfg.mode) carry = sub_rise[cfg.sel];
        else          carry = main_rise[cfg.sel];
    end

endmodule

// File: rtl/tapdog_fsm.sv
module tapdog_fsm
    import tapdog_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       carry,
    input  logic       wr_zero,
    input  logic       wr_mode,
    input  logic [1:0] wr_sel,
    input  logic       clr_ext,
    input  logic       lp_any,
    output wd_cfg_t    cfg,
    output logic       running,
    output logic       rst_req
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    wd_cfg_t          cfg_q, cfg_d;
    logic             fire_d;
    logic             rst_req_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cfg_d   = cfg_q;
        fire_d  = 1'b0;
        unique case (state_q)
            ST_STOP: begin
                if (wr_zero) begin                       // START
                    cfg_d.mode = wr_mode;
                    cfg_d.sel  = wr_sel;
                    cnt_d      = '0;
                    state_d    = lp_any ? ST_SUSPEND : ST_RUN;
                end
            end
            ST_RUN: begin
                if (lp_any) begin                        // SLEEP_IN
                    cnt_d   = '0;
                    state_d = ST_SUSPEND;
                end else if (wr_zero || clr_ext) begin
                    cnt_d = '0;
                end else if (carry) begin
                    if (cnt_q == CNT_MAX) begin          // BITE
                        fire_d  = 1'b1;
                        cnt_d   = '0;
                        state_d = ST_STOP;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_SUSPEND: begin
                cnt_d = '0;
                if (!lp_any) state_d = ST_RUN;           // WAKE
            end
            default: begin
                cnt_d   = '0;
                state_d = ST_STOP;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_STOP;
            cnt_q   <= '0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cfg_q   <= cfg_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) rst_req_q <= 1'b0;
        else        rst_req_q <= fire_d;
    end

    assign cfg     = cfg_q;
    assign running = (state_q != ST_STOP);
    assign rst_req = rst_req_q;

endmodule

// File: rtl/tapdog_wdt.sv
module tapdog_wdt
    import tapdog_pkg::*;
#(
    parameter int MAIN_PRE_W = MAIN_W,
    parameter int SUB_PRE_W  = SUB_W
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  osc_sel,
    input  logic [1:0]            ival_sel,
    input  logic                  wr_en,
    input  logic                  wr_ctl_bit,
    input  logic [MAIN_PRE_W-1:0] main_pre,
    input  logic [SUB_PRE_W-1:0]  sub_pre,
    input  logic                  ext_rst,
    input  logic                  sw_rst,
    input  logic                  lp_sleep,
    input  logic                  lp_tbase,
    input  logic                  lp_stop,
    output logic                  rst_req,
    output logic                  running
);

    logic [N_IVAL-1:0] main_taps;
    logic [N_IVAL-1:0] sub_taps;
    wd_cfg_t           cfg;
    logic              carry;
    logic              wr_zero;
    logic              clr_ext;
    logic              lp_any;

    assign wr_zero = wr_en & ~wr_ctl_bit;
    assign clr_ext = ext_rst | sw_rst;
    assign lp_any  = lp_sleep | lp_tbase | lp_stop;

    tapdog_tap_pick #(.W(MAIN_PRE_W), .SUB_MODE(1'b0)) u_main_pick (
        .pre  (main_pre),
        .taps (main_taps)
    );

    tapdog_tap_pick #(.W(SUB_PRE_W), .SUB_MODE(1'b1)) u_sub_pick (
        .pre  (sub_pre),
        .taps (sub_taps)
    );

    tapdog_carry u_carry (
        .clk       (clk),
        .por_n     (por_n),
        .main_taps (main_taps),
        .sub_taps  (sub_taps),
        .cfg       (cfg),
        .carry     (carry)
    );

    tapdog_fsm u_fsm (
        .clk     (clk),
        .por_n   (por_n),
        .carry   (carry),
        .wr_zero (wr_zero),
        .wr_mode (osc_sel),
        .wr_sel  (ival_sel),
        .clr_ext (clr_ext),
        .lp_any  (lp_any),
        .cfg     (cfg),
        .running (running),
        .rst_req (rst_req)
    );

endmodule

// File: rtl/tapdog_chk.sv
module tapdog_chk (
    input logic clk,
    input logic por_n,
    input logic wr_en,
    input logic wr_ctl_bit,
    input logic ext_rst,
    input logic sw_rst,
    input logic lp_sleep,
    input logic lp_tbase,
    input logic lp_stop,
    input logic rst_req,
    input logic running
);

    logic lp_any_c;
    assign lp_any_c = lp_sleep | lp_tbase | lp_stop;

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req);

    p_pulse_stopped_r4: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> !running);

    p_fall_only_by_bite_r4: assert property (@(posedge clk) disable iff (!por_n)
        $fell(running) |-> rst_req);

    p_start_r2: assert property (@(posedge clk) disable iff (!por_n)
        (!running && wr_en && !wr_ctl_bit) |=> running);

    p_stay_stopped_r10: assert property (@(posedge clk) disable iff (!por_n)
        (!running && !(wr_en && !wr_ctl_bit)) |=> !running);

    p_clear_beats_carry_r9: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !wr_ctl_bit) |=> !rst_req);

    p_ext_clear_r7: assert property (@(posedge clk) disable iff (!por_n)
        (ext_rst || sw_rst) |=> !rst_req);

    p_lowpower_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
        lp_any_c |=> !rst_req);

    p_keep_running_r7: assert property (@(posedge clk) disable iff (!por_n)
        (running && (ext_rst || sw_rst)) |=> running);

endmodule

bind tapdog_wdt tapdog_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .wr_en      (wr_en),
    .wr_ctl_bit (wr_ctl_bit),
    .ext_rst    (ext_rst),
    .sw_rst     (sw_rst),
    .lp_sleep   (lp_sleep),
    .lp_tbase   (lp_tbase),
    .lp_stop    (lp_stop),
    .rst_req    (rst_req),
    .running    (running)
);

// File: tb/tapdog_wdt_bench.sv
`timescale 1ns/1ps
module tapdog_wdt_bench;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        osc_sel = 1'b0;
    logic [1:0]  ival_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic        wr_ctl_bit = 1'b1;
    logic [18:0] main_pre = '0;
    logic [14:0] sub_pre = '0;
    logic        ext_rst = 1'b0;
    logic        sw_rst = 1'b0;
    logic        lp_sleep = 1'b0;
    logic        lp_tbase = 1'b0;
    logic        lp_stop = 1'b0;
    logic        rst_req;
    logic        running;

    logic        main_clr = 1'b0;
    logic        sub_clr = 1'b0;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #5 clk = ~clk;

    tapdog_wdt u_tapdog_wdt (
        .clk(clk), .por_n(por_n), .osc_sel(osc_sel), .ival_sel(ival_sel),
        .wr_en(wr_en), .wr_ctl_bit(wr_ctl_bit), .main_pre(main_pre),
        .sub_pre(sub_pre), .ext_rst(ext_rst), .sw_rst(sw_rst),
        .lp_sleep(lp_sleep), .lp_tbase(lp_tbase), .lp_stop(lp_stop),
        .rst_req(rst_req), .running(running)
    );

    // ---------------- reference model ----------------
    bit          m_run, m_susp, m_mode, exp_rst;
    int          m_cnt, m_sel;
    logic [18:0] m_mprev;
    logic [14:0] m_sprev;

    function automatic int tpos(bit mode, int sel);
        int mt[4] = '{11, 13, 15, 18};
        int st[4] = '{9, 12, 13, 14};
        return mode ? st[sel] : mt[sel];
    endfunction

    function automatic bit rise_now(logic [18:0] mc, logic [14:0] sc);
        int p;
        p = tpos(m_mode, m_sel);
        if (m_mode) return sc[p] && !m_sprev[p];
        return mc[p] && !m_mprev[p];
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_run = 0; m_susp = 0; m_cnt = 0; m_mode = 0; m_sel = 0;
            exp_rst = 0; m_mprev = '0; m_sprev = '0;
        end else begin
            bit lp, wz, cl, e, fire;
            lp = lp_sleep || lp_tbase || lp_stop;
            wz = wr_en && !wr_ctl_bit;
            cl = ext_rst || sw_rst;
            e  = rise_now(main_pre, sub_pre);
            fire = 0;
            if (!m_run) begin
                if (wz) begin
                    m_run = 1; m_mode = osc_sel; m_sel = ival_sel; m_cnt = 0; m_susp = lp;
                end
            end else if (m_susp) begin
                m_cnt = 0;
                if (!lp) m_susp = 0;
            end else if (lp) begin
                m_cnt = 0; m_susp = 1;
            end else if (wz || cl) begin
                m_cnt = 0;
            end else if (e) begin
                if (m_cnt == 3) begin fire = 1; m_run = 0; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            exp_rst = fire;
            m_mprev = main_pre;
            m_sprev = sub_pre;
        end
    end

    // compare on every clock, then advance the prescalers
    always @(negedge clk) begin
        if (!done) begin
            compared++;
            if (rst_req !== exp_rst || running !== m_run) begin
                mismatched++;
                $display("FAIL %s cycle compare: rst_req=%0b running=%0b expected rst_req=%0b running=%0b",
                         cur_req, rst_req, running, exp_rst, m_run);
            end
        end
        main_pre <= main_clr ? '0 : main_pre + 1'b1;
        sub_pre  <= sub_clr  ? '0 : sub_pre + 1'b1;
    end

    task automatic chk(string req, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_rng(string req, int act, int lo, int hi);
        compared++;
        if (act < lo || act > hi) begin
            mismatched++;
            $display("FAIL %s: actual=%0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit ctl, bit mode, int sel);
        @(negedge clk);
        wr_en = 1; wr_ctl_bit = ctl; osc_sel = mode; ival_sel = sel[1:0];
        @(negedge clk);
        wr_en = 0; wr_ctl_bit = 1;
    endtask

    task automatic wait_bite(int maxc, output int n);
        n = 0;
        while (!rst_req && n < maxc) begin @(negedge clk); n++; end
    endtask

    // drive a stimulus exactly into the cycle of the overflow carry
    task automatic hit_overflow(int kind);
        bit hit = 0;
        int guard = 0;
        while (!hit && guard < 20000) begin
            @(negedge clk); #1;
            guard++;
            if (m_run && !m_susp && m_cnt == 3 && rise_now(main_pre, sub_pre)) begin
                hit = 1;
                if (kind == 0) begin wr_en = 1; wr_ctl_bit = 0; end
                else ext_rst = 1;
            end
        end
        @(negedge clk);
        wr_en = 0; wr_ctl_bit = 1; ext_rst = 0;
        chk("R9 collision reached", hit, 1'b1);
        chk("R9 no bite after clear", rst_req, 1'b0);
        chk("R9 still running", running, 1'b1);
    endtask

    initial begin
        int n;
        // R1
        cyc(3);
        chk("R1 reset rst_req", rst_req, 1'b0);
        chk("R1 reset running", running, 1'b0);
        @(negedge clk); #2 por_n = 1;
        wr(1, 0, 0);
        cyc(3);
        chk("R1 ctl=1 no start", running, 1'b0);

        // R2, R3, R4 main sel0: bit 11, period 4096
        cur_req = "R4";
        wr(0, 0, 0);
        chk("R2 started", running, 1'b1);
        wait_bite(20000, n);
        chk("R4 bite pulse", rst_req, 1'b1);
        chk("R4 stopped at bite", running, 1'b0);
        chk_rng("R3 main sel0 interval", n, 3 * 4096 - 2, 4 * 4096 + 2);
        cyc(1);
        chk("R4 single cycle", rst_req, 1'b0);
        cur_req = "R10";
        cyc(300);
        chk("R10 stays stopped", running, 1'b0);

        // R5, R6: sub sel0 (bit 9, period 1024); writes with other settings
        cur_req = "R6";
        wr(0, 1, 0);
        repeat (3) begin
            cyc(900);
            wr(1, 0, 3);
            cyc(900);
            wr(0, 0, 3);
        end
        chk("R5 no bite under clears", running, 1'b1);
        wait_bite(8000, n);
        chk("R6 bite present", rst_req, 1'b1);
        chk_rng("R6 kept sub sel0", n, 3 * 1024 - 2, 4 * 1024 + 2);

        // R7: external and software reset clear
        cur_req = "R7";
        wr(0, 1, 0);
        repeat (4) begin
            cyc(1500);
            @(negedge clk); ext_rst = 1; @(negedge clk); ext_rst = 0;
            cyc(1500);
            @(negedge clk); sw_rst = 1; @(negedge clk); sw_rst = 0;
        end
        chk("R7 still running", running, 1'b1);

        // R8: low-power modes suspend
        cur_req = "R8";
        @(negedge clk); lp_sleep = 1; cyc(5000); lp_sleep = 0;
        chk("R8 sleep no bite", running, 1'b1);
        cyc(2000);
        @(negedge clk); lp_tbase = 1; cyc(3000); lp_tbase = 0;
        cyc(2000);
        @(negedge clk); lp_stop = 1; cyc(3000);
        chk("R8 stop held", running, 1'b1);
        lp_stop = 0;
        wait_bite(8000, n);
        chk("R8 bite after wake", rst_req, 1'b1);
        chk_rng("R8 counting resumed", n, 3 * 1024 - 2, 4 * 1024 + 2);

        // R9: clear in overflow cycle
        cur_req = "R9";
        wr(0, 1, 0);
        hit_overflow(0);
        hit_overflow(1);
        wait_bite(8000, n);
        chk("R9 later bite", rst_req, 1'b1);

        // R11: prescaler clear lengthens interval
        cur_req = "R11";
        wr(0, 1, 0);
        n = 0;
        repeat (10) begin
            cyc(400);
            @(negedge clk); sub_clr = 1; @(negedge clk); sub_clr = 0;
        end
        begin
            int m;
            wait_bite(8000, m);
            chk("R11 bite present", rst_req, 1'b1);
            chk_rng("R11 lengthened", 4020 + m, 4609, 12000);
        end

        // R3 other selection: sub sel1 (bit 12, period 8192), started mid-phase
        cur_req = "R3";
        cyc(777);
        wr(0, 1, 1);
        wait_bite(40000, n);
        chk("R3 sub sel1 bite", rst_req, 1'b1);
        chk_rng("R3 sub sel1 interval", n, 3 * 8192 - 2, 4 * 8192 + 2);

        // R1: power-on reset while running
        cur_req = "R1";
        wr(0, 0, 0);
        cyc(100);
        @(negedge clk); #2 por_n = 0;
        cyc(2);
        chk("R1 por stops", running, 1'b0);
        @(negedge clk); #2 por_n = 1;
        cyc(200);
        chk("R1 stays stopped after por", running, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule